// File: doc/BRIEF.md
# USB Host Interrupt Enable and Status Unit

This unit holds the interrupt bookkeeping of a USB host controller: a sticky status register fed by single-cycle event pulses, a per-event enable register with a master enable, and a clear-only alias of that enable register. Each event pulse is recorded into its status bit only while both its own enable and the master enable are set. Software reads and clears the recorded bits through a 32-bit register port with byte strobes.

A routing input selects where recorded events go. With routing low, a level interrupt line stays high while any enabled status bit is set under the master enable. With routing high, the level line is held low and every recorded event instead produces a single-cycle pulse on a management interrupt output. A separate ownership-change request, written by software into a command word, sets a dedicated status bit and, when both the master and the ownership enables are set, also produces a management pulse.

The management pulse comes from a three-state machine. SMI_IDLE is the rest state; a trigger moves it to SMI_FIRE, the only state in which the output is high. SMI_FIRE always moves to SMI_GAP, which holds the output low for one cycle. SMI_GAP returns to SMI_FIRE when a trigger arrives or one is remembered from the SMI_FIRE cycle, and to SMI_IDLE otherwise. At most one trigger is remembered.

Top module: `usb_irq_ctl`

## Requirements
- R1: After reset every enable and status bit is 0, both reads return 0, and irq and smi are 0.
- R2: A write to the enable word (byte offset 0x08) with byte strobe 0 set ORs data bits 6:0 into the event enables; reading offset 0x08 or offset 0x0C returns the enable word (event enables in bits 6:0, ownership enable in bit 30, master enable in bit 31, other bits 0).
- R3: A write to the disable word (offset 0x0C) with strobe 0 clears each event enable whose data bit is 1 and leaves the others unchanged.
- R4: Under strobe 3, data bit 31 set at offset 0x08 sets the master enable and at offset 0x0C clears it; data bit 30 does the same for the ownership enable.
- R5: An event pulse on ev_pulse[i] (0 scheduling overrun, 1 done-queue written, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame-number overflow, 6 root-hub change) sets status bit i at the next clock edge only if the master enable and event enable i are set.
- R6: Writing the status word (offset 0x04) clears status bits 6:0 that are 1 in the data under strobe 0 and bit 30 under strobe 3; strobes 1 and 2 have no effect; an event recorded in the same cycle as its clear leaves the bit set.
- R7: With routing low, irq is 1 exactly while the master enable is set and some status bit 6:0 has its enable set, following register changes in the cycle after the edge.
- R8: With routing high, irq is 0 and each recorded event gives smi high for exactly one cycle, starting in the cycle after the recording edge.
- R9: Writing the command word (offset 0x00) with data bit 3 under strobe 0 sets status bit 30; it raises an smi pulse only if the master and ownership enables are both set.
- R10: Two triggers on consecutive edges give smi pulses in the first and third cycles after the first edge, with smi low between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 8 | Byte address of the written word |
| wr_strb | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read word |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_pulse | input | 7 | Event pulses, one bit per event |
| route_mgmt | input | 1 | 1 routes events to smi, 0 to irq |
| irq | output | 1 | Level interrupt |
| smi | output | 1 | Management interrupt, single-cycle pulse |

## Verification
The bench builds the unit with its default parameters: seven events, an 8-bit byte address and the offsets 0x00, 0x04, 0x08 and 0x0C. With seven events every event position, including the gated ones above the enabled set, can be pulsed at once, and the narrow address space keeps strobe-ignored byte lanes and alias reads directly reachable. The same defaults let the management state machine be driven through SMI_FIRE, SMI_GAP and back to SMI_FIRE with two back-to-back events.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W       = 32;
    localparam int EV_W        = 7;
    localparam int MASTER_BIT  = 31;
    localparam int OWN_BIT     = 30;
    localparam int OWN_REQ_BIT = 3;
    localparam int RSV_W       = REG_W - 2 - EV_W;

    typedef enum logic [1:0] {
        SMI_IDLE = 2'd0,
        SMI_FIRE = 2'd1,
        SMI_GAP  = 2'd2
    } smi_state_e;

    typedef struct packed {
        logic [EV_W-1:0] en_set;
        logic [EV_W-1:0] en_clr;
        logic [EV_W-1:0] st_clr;
        logic            master_set;
        logic            master_clr;
        logic            own_en_set;
        logic            own_en_clr;
        logic            own_st_clr;
        logic            own_req;
    } wr_cmd_t;

endpackage

// File: rtl/usb_irq_regif.sv
module usb_irq_regif
    import usb_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] ST_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] ENA_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] DIS_OFS = 8'h0C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_strb,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  en_view,
    input  logic [REG_W-1:0]  st_view,
    output wr_cmd_t           cmd,
    output logic [REG_W-1:0]  rd_data
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic hit_cmd, hit_st, hit_ena, hit_dis;

    assign wr_word = wr_addr[ADDR_W-1:2];
    assign rd_word = rd_addr[ADDR_W-1:2];

    assign hit_cmd = wr_en && (wr_word == CMD_OFS[ADDR_W-1:2]);
    assign hit_st  = wr_en && (wr_word == ST_OFS[ADDR_W-1:2]);
    assign hit_ena = wr_en && (wr_word == ENA_OFS[ADDR_W-1:2]);
    assign hit_dis = wr_en && (wr_word == DIS_OFS[ADDR_W-1:2]);

    // Write decode: byte lane 0 carries event bits, lane 3 the high controls.
    always_comb begin
        cmd = '0;
        if (hit_ena && wr_strb[0]) begin
            cmd.en_set = wr_data[EV_W-1:0];
        end
        if (hit_ena && wr_strb[3]) begin
            cmd.master_set = wr_data[MASTER_BIT];
            cmd.own_en_set = wr_data[OWN_BIT];
        end
        if (hit_dis && wr_strb[0]) begin
            cmd.en_clr = wr_data[EV_W-1:0];
        end
        if (hit_dis && wr_strb[3]) begin
            cmd.master_clr = wr_data[MASTER_BIT];
            cmd.own_en_clr = wr_data[OWN_BIT];
        end
        if (hit_st && wr_strb[0]) begin
            cmd.st_clr = wr_data[EV_W-1:0];
        end
        if (hit_st && wr_strb[3]) begin
            cmd.own_st_clr = wr_data[OWN_BIT];
        end
        if (hit_cmd && wr_strb[0]) begin
            cmd.own_req = wr_data[OWN_REQ_BIT];
        end
    end

    // Read mux: the disable word reads back the enable contents.
    always_comb begin
        rd_data = '0;
        if ((rd_word == ENA_OFS[ADDR_W-1:2]) || (rd_word == DIS_OFS[ADDR_W-1:2])) begin
            rd_data = en_view;
        end else if (rd_word == ST_OFS[ADDR_W-1:2]) begin
            rd_data = st_view;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[REG_W-3:EV_W], wr_strb[2:1]};

endmodule

// File: rtl/usb_irq_enable.sv
module usb_irq_enable
    import usb_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  wr_cmd_t         cmd,
    output logic [EV_W-1:0] en_ev,
    output logic            master_en,
    output logic            own_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_ev     <= '0;
            master_en <= 1'b0;
            own_en    <= 1'b0;
        end else begin
            en_ev     <= (en_ev & ~cmd.en_clr) | cmd.en_set;
            master_en <= (master_en & ~cmd.master_clr) | cmd.master_set;
            own_en    <= (own_en & ~cmd.own_en_clr) | cmd.own_en_set;
        end
    end

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  wr_cmd_t         cmd,
    input  logic [EV_W-1:0] ev_pulse,
    input  logic [EV_W-1:0] en_ev,
    input  logic            master_en,
    output logic [EV_W-1:0] st_ev,
    output logic            st_own,
    output logic [EV_W-1:0] ev_hit
);

    // One sticky bit per event; a recorded event wins over a same-cycle clear.
    for (genvar i = 0; i < EV_W; i++) begin : g_bit
        assign ev_hit[i] = ev_pulse[i] & en_ev[i] & master_en;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_ev[i] <= 1'b0;
            end else begin
                st_ev[i] <= (st_ev[i] & ~cmd.st_clr[i]) | ev_hit[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_own <= 1'b0;
        end else begin
            st_own <= (st_own & ~cmd.own_st_clr) | cmd.own_req;
        end
    end

endmodule

// File: rtl/usb_irq_smi_fsm.sv
module usb_irq_smi_fsm
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic smi
);

    smi_state_e state_q, state_d;
    logic       pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            SMI_IDLE: begin
                pend_d = 1'b0;
                if (trig) begin
                    state_d = SMI_FIRE;
                end
            end
            SMI_FIRE: begin
                state_d = SMI_GAP;
                if (trig) begin
                    pend_d = 1'b1;
                end
            end
            SMI_GAP: begin
                pend_d = 1'b0;
                if (trig || pend_q) begin
                    state_d = SMI_FIRE;
                end else begin
                    state_d = SMI_IDLE;
                end
            end
            default: begin
                state_d = SMI_IDLE;
                pend_d  = 1'b0;
            end
        endcase
    end

    always_comb begin
        smi = (state_q == SMI_FIRE);
    end

endmodule

// File: rtl/usb_irq_ctl.sv
module usb_irq_ctl
    import usb_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] ST_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] ENA_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] DIS_OFS = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_strb,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [EV_W-1:0]   ev_pulse,
    input  logic              route_mgmt,
    output logic              irq,
    output logic              smi
);

    wr_cmd_t         cmd;
    logic [EV_W-1:0] en_ev;
    logic            master_en;
    logic            own_en;
    logic [EV_W-1:0] st_ev;
    logic            st_own;
    logic [EV_W-1:0] ev_hit;
    logic [REG_W-1:0] en_view;
    logic [REG_W-1:0] st_view;
    logic            smi_trig;

    assign en_view = {master_en, own_en, {RSV_W{1'b0}}, en_ev};
    assign st_view = {1'b0, st_own, {RSV_W{1'b0}}, st_ev};

    usb_irq_regif #(
        .ADDR_W (ADDR_W),
        .CMD_OFS(CMD_OFS),
        .ST_OFS (ST_OFS),
        .ENA_OFS(ENA_OFS),
        .DIS_OFS(DIS_OFS)
    ) u_regif (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_strb(wr_strb),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .en_view(en_view),
        .st_view(st_view),
        .cmd    (cmd),
        .rd_data(rd_data)
    );

    usb_irq_enable u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .en_ev    (en_ev),
        .master_en(master_en),
        .own_en   (own_en)
    );

    usb_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ev_pulse (ev_pulse),
        .en_ev    (en_ev),
        .master_en(master_en),
        .st_ev    (st_ev),
        .st_own   (st_own),
        .ev_hit   (ev_hit)
    );

    // Management triggers: a routed event record, or an enabled ownership request.
    assign smi_trig = (route_mgmt && (|ev_hit))
                    || (cmd.own_req && master_en && own_en);

    usb_irq_smi_fsm u_smi (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (smi_trig),
        .smi  (smi)
    );

    assign irq = !route_mgmt && master_en && (|(st_ev & en_ev));

endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
    import usb_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [3:0]        wr_strb,
    input logic [REG_W-1:0]  wr_data,
    input logic [EV_W-1:0]   ev_pulse,
    input logic              route_mgmt,
    input logic              irq,
    input logic              smi,
    input logic [REG_W-1:0]  en_view,
    input logic [REG_W-1:0]  st_view
);

    logic [EV_W-1:0] gated_ev;
    logic            own_write;

    assign gated_ev  = ev_pulse & en_view[EV_W-1:0];
    assign own_write = wr_en && (wr_addr[ADDR_W-1:2] == CMD_OFS[ADDR_W-1:2])
                     && wr_strb[0] && wr_data[OWN_REQ_BIT];

    AST_EV_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_view[MASTER_BIT] && (|gated_ev)) |=>
        ((st_view[EV_W-1:0] & $past(gated_ev)) == $past(gated_ev))); // R5

    AST_NO_SET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_view[MASTER_BIT] && !wr_en) |=> $stable(st_view)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> (irq || route_mgmt)); // R7

    AST_MGMT_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        route_mgmt |-> !irq); // R8

    AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smi |=> !smi); // R10

    AST_OWN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_view[OWN_BIT]) |-> $past(own_write)); // R9

endmodule

bind usb_irq_ctl usb_irq_chk #(
    .ADDR_W (ADDR_W),
    .CMD_OFS(CMD_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_strb   (wr_strb),
    .wr_data   (wr_data),
    .ev_pulse  (ev_pulse),
    .route_mgmt(route_mgmt),
    .irq       (irq),
    .smi       (smi),
    .en_view   (en_view),
    .st_view   (st_view)
);

// File: tb/sim_usb_irq_ctl.sv
module sim_usb_irq_ctl;

    localparam int CLK_P = 10;
    localparam logic [7:0] A_CMD = 8'h00;
    localparam logic [7:0] A_ST  = 8'h04;
    localparam logic [7:0] A_ENA = 8'h08;
    localparam logic [7:0] A_DIS = 8'h0C;

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_SMI = 2;

    typedef struct {
        int          kind;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [6:0]  ev_pulse = '0;
    logic        route_mgmt = 1'b0;
    logic        irq;
    logic        smi;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    mon_busy = 0;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    usb_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ev_pulse(ev_pulse), .route_mgmt(route_mgmt),
        .irq(irq), .smi(smi)
    );

    // Monitor: pops expected items at each falling edge and compares.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] got;
        mon_busy = 1;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            if (it.kind == K_RD) begin
                rd_addr = it.addr;
                #1;
                got = rd_data;
            end else if (it.kind == K_IRQ) begin
                got = {31'd0, irq};
            end else begin
                got = {31'd0, smi};
            end
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s got=%h exp=%h", it.req, got, it.exp);
            end
        end
        mon_busy = 0;
    end

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.kind = kind;
        it.addr = a;
        it.exp  = e;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        wait (sb_q.size() == 0 && !mon_busy);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d,
                      input logic [6:0] ev);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d; ev_pulse = ev;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_strb = '0; wr_data = '0; ev_pulse = '0;
    endtask

    task automatic pulse(input logic [6:0] ev);
        @(negedge clk);
        ev_pulse = ev;
        @(posedge clk);
        #1;
        ev_pulse = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(K_IRQ, 0, 0, "R1 irq after reset");
        chk(K_SMI, 0, 0, "R1 smi after reset");
        chk(K_RD, A_ENA, 32'h0, "R1 enable after reset");
        chk(K_RD, A_ST, 32'h0, "R1 status after reset");
        settle();

        wr(A_ENA, 4'b0001, 32'h05, 0);
        wr(A_ENA, 4'b0001, 32'h02, 0);
        chk(K_RD, A_ENA, 32'h07, "R2 enable OR-set");
        chk(K_RD, A_DIS, 32'h07, "R2 disable alias read");
        settle();

        pulse(7'h01);
        chk(K_RD, A_ST, 32'h0, "R5 master off blocks record");
        chk(K_IRQ, 0, 0, "R7 irq low, nothing recorded");
        settle();

        wr(A_ENA, 4'b1000, 32'h8000_0000, 0);
        chk(K_RD, A_ENA, 32'h8000_0007, "R4 master set");
        settle();

        pulse(7'h7F);
        chk(K_RD, A_ST, 32'h07, "R5 only enabled events record");
        chk(K_IRQ, 0, 1, "R7 irq raised");
        settle();

        wr(A_ST, 4'b0110, 32'h00FF_FF00, 0);
        chk(K_RD, A_ST, 32'h07, "R6 lanes 1 and 2 ignored");
        settle();

        wr(A_ST, 4'b0001, 32'h03, 0);
        chk(K_RD, A_ST, 32'h04, "R6 W1C partial");
        chk(K_IRQ, 0, 1, "R7 irq held by remaining bit");
        settle();
        wr(A_ST, 4'b0001, 32'h04, 0);
        chk(K_IRQ, 0, 0, "R7 irq drops when cleared");
        settle();

        wr(A_DIS, 4'b0001, 32'h02, 0);
        chk(K_RD, A_ENA, 32'h8000_0005, "R3 disable clears one bit");
        settle();
        pulse(7'h02);
        chk(K_RD, A_ST, 32'h0, "R3 disabled event not recorded");
        settle();

        pulse(7'h01);
        wr(A_ST, 4'b0001, 32'h01, 7'h01);
        chk(K_RD, A_ST, 32'h01, "R6 record wins over clear");
        settle();

        wr(A_DIS, 4'b1000, 32'h8000_0000, 0);
        chk(K_RD, A_DIS, 32'h0000_0005, "R4 master cleared via disable");
        chk(K_IRQ, 0, 0, "R7 irq gated by master");
        chk(K_RD, A_ST, 32'h01, "R7 status kept under master off");
        settle();
        wr(A_ENA, 4'b1000, 32'h8000_0000, 0);
        chk(K_IRQ, 0, 1, "R7 irq back with master");
        settle();
        wr(A_ST, 4'b0001, 32'h01, 0);
        settle();

        @(negedge clk);
        route_mgmt = 1'b1;
        pulse(7'h04);
        chk(K_SMI, 0, 1, "R8 smi pulse on routed event");
        chk(K_IRQ, 0, 0, "R8 irq muted in management routing");
        chk(K_RD, A_ST, 32'h04, "R8 event recorded");
        settle();
        chk(K_SMI, 0, 0, "R8 smi single cycle");
        settle();
        @(negedge clk);
        route_mgmt = 1'b0;
        #1;
        chk(K_IRQ, 0, 1, "R7 irq after routing back");
        settle();
        wr(A_ST, 4'b0001, 32'h04, 0);
        settle();

        wr(A_CMD, 4'b0001, 32'h08, 0);
        chk(K_RD, A_ST, 32'h4000_0000, "R9 ownership status set");
        chk(K_SMI, 0, 0, "R9 no smi without ownership enable");
        settle();
        wr(A_ST, 4'b1000, 32'h4000_0000, 0);
        chk(K_RD, A_ST, 32'h0, "R6 bit 30 W1C");
        settle();
        wr(A_ENA, 4'b1000, 32'h4000_0000, 0);
        chk(K_RD, A_ENA, 32'hC000_0005, "R4 ownership enable set");
        settle();
        wr(A_CMD, 4'b0001, 32'h08, 0);
        chk(K_SMI, 0, 1, "R9 smi on enabled ownership request");
        chk(K_IRQ, 0, 0, "R9 ownership bit does not drive irq");
        settle();
        chk(K_SMI, 0, 0, "R9 smi ends");
        settle();
        wr(A_ST, 4'b1000, 32'h4000_0000, 0);
        settle();

        @(negedge clk);
        route_mgmt = 1'b1;
        ev_pulse = 7'h01;
        @(posedge clk);
        #1;
        chk(K_SMI, 0, 1, "R10 first pulse");
        settle();
        @(posedge clk);
        #1 ev_pulse = '0;
        chk(K_SMI, 0, 0, "R10 gap cycle");
        settle();
        chk(K_SMI, 0, 1, "R10 second pulse");
        settle();
        chk(K_SMI, 0, 0, "R10 back to low");
        chk(K_RD, A_ST, 32'h01, "R10 events recorded");
        settle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule